// File: doc/BRIEF.md
# Brown-Out Monitor Control Logic

This block is the digital half of a brown-out monitor. Two analog comparators sit outside it. One flags that the internal supply has fallen under its threshold, the other flags the same for an external sense pin. Both arrive here as raw level signals, each set to 1 while its input is below threshold. The block synchronises them and picks one according to a select bit. Depending on a mode bit, it then gives either a one-cycle interrupt pulse at every threshold crossing, or a reset request that stays high for as long as the monitored voltage is low.

Software reaches the block through one 8-bit control/status register on a plain synchronous write port with a combinational read port. The block also records, at the moment a system reset begins, whether its own reset request caused that reset. A reset it caused keeps the configuration, so the monitor stays armed while the supply recovers. Any other reset puts the register back to a default chosen by a static option input. An asynchronous power-on reset clears everything, including the recorded cause.

Top module: `bod_ctrl`

## Requirements
- R1: The register reads as {arm, 0, 0, 0, 0, src, mode, flag}: bit 7 enables detection, bit 2 selects the source, bit 1 selects reset mode (1) or interrupt mode (0), and bits 6..3 read 0. A write outside system reset updates bits 7, 2 and 1 at the next clock edge.
- R2: The flag (bit 0) reads 1 only while arm is 1 and the selected comparator is 1. src=0 selects cmp_supply_low and src=1 selects cmp_ext_low. A change on a comparator input shows on the flag after the second clock edge.
- R3: The flag is read-only. The value written to bit 0 has no effect on anything the register reads back.
- R4: With arm=1 and mode=0, each change of the selected synchronised level, in either direction, gives exactly one irq_pulse cycle, after the third clock edge following the input change.
- R5: With arm=1 and mode=1, rst_req is high exactly while the selected synchronised level is 1, and no interrupt is raised.
- R6: With arm=0, the block gives no interrupt and no reset request, and the flag reads 0, whatever the comparators do.
- R7: Writing a new src value, or setting arm, gives no interrupt from the level difference between the old and new selections.
- R8: Power-on reset, and any system reset not caused by rst_req, load 0x82 when opt_off=0 and 0x00 when opt_off=1.
- R9: The first cycle of a system reset records whether rst_req was high. last_rst_self shows the recorded value until the next reset begins. When the recorded value is 1, the reset leaves arm, src and mode unchanged.
- R10: Register writes made while sys_rst is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sys_rst | input | 1 | Synchronous system reset from the reset controller, active high |
| opt_off | input | 1 | Static option: 1 makes a full reset leave detection off |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| cmp_supply_low | input | 1 | Internal supply comparator, 1 = below threshold |
| cmp_ext_low | input | 1 | External pin comparator, 1 = below threshold |
| irq_pulse | output | 1 | One-cycle interrupt per crossing |
| rst_req | output | 1 | Reset request, level-held while low |
| last_rst_self | output | 1 | Last reset was requested by this block |

## Verification
The bench switches the source while the two comparators disagree. A design that reloads nothing on a select change would fire an interrupt there. It writes all ones to the register and expects bit 0 to follow the comparator, which catches a flag that stores written data. It drives a reset while rst_req is high and writes zero during that reset, then runs a plain reset. A design that decides the cause from the current request instead of the one recorded at reset entry, or that accepts writes during reset, would lose or wrongly keep the configuration. Random comparator toggles, writes and short resets are compared cycle by cycle against a reference model in the bench.

// File: rtl/bod_pkg.sv
package bod_pkg;
  localparam int REG_W    = 8;
  localparam int ARM_BIT  = 7;
  localparam int SRC_BIT  = 2;
  localparam int MODE_BIT = 1;
  localparam int FLAG_BIT = 0;

  typedef struct packed {
    logic arm;
    logic src;
    logic mode;
  } bod_cfg_t;

  // default after a full (non-preserving) reset
  function automatic bod_cfg_t cfg_default(input logic off);
    bod_cfg_t c;
    c.arm  = ~off;
    c.src  = 1'b0;
    c.mode = ~off;
    return c;
  endfunction

  function automatic bod_cfg_t cfg_from_bus(input logic [REG_W-1:0] d);
    bod_cfg_t c;
    c.arm  = d[ARM_BIT];
    c.src  = d[SRC_BIT];
    c.mode = d[MODE_BIT];
    return c;
  endfunction

  // lv[0] = supply comparator, lv[1] = external comparator
  function automatic logic pick_level(input logic src, input logic [1:0] lv);
    return src ? lv[1] : lv[0];
  endfunction

  function automatic logic [REG_W-1:0] pack_status(input bod_cfg_t c, input logic flag);
    logic [REG_W-1:0] r;
    r = '0;
    r[ARM_BIT]  = c.arm;
    r[SRC_BIT]  = c.src;
    r[MODE_BIT] = c.mode;
    r[FLAG_BIT] = flag;
    return r;
  endfunction
endpackage

// File: rtl/bod_sync.sv
module bod_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge por_n)
        if (!por_n) chain[g] <= '0;
        else        chain[g] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge por_n)
        if (!por_n) chain[g] <= '0;
        else        chain[g] <= chain[g-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/bod_cfg_reg.sv
module bod_cfg_reg
  import bod_pkg::*;
(
  input  logic             clk,
  input  logic             por_n,
  input  logic             opt_off,
  input  logic             sys_rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rst_req,
  output bod_cfg_t         cfg,
  output logic             cause
);
  bod_cfg_t cfg_q;
  logic     cause_q;
  logic     in_rst_q;
  logic     rst_entry;
  logic     self_now;

  assign rst_entry = sys_rst && !in_rst_q;
  assign self_now  = rst_entry ? rst_req : cause_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cfg_q    <= cfg_default(opt_off);
      cause_q  <= 1'b0;
      in_rst_q <= 1'b0;
    end else begin
      in_rst_q <= sys_rst;
      if (sys_rst) begin
        if (rst_entry) cause_q <= rst_req;
        if (!self_now) cfg_q <= cfg_default(opt_off);
      end else if (wr_en) begin
        cfg_q <= cfg_from_bus(wr_data);
      end
    end
  end

  assign cfg   = cfg_q;
  assign cause = cause_q;

  // R8
  default_load_chk: assert property (@(posedge clk) disable iff (!por_n)
    (sys_rst && !self_now) |=> (cfg_q == cfg_default($past(opt_off))));
  // R9
  preserve_cfg_chk: assert property (@(posedge clk) disable iff (!por_n)
    (sys_rst && self_now) |=> $stable(cfg_q));
  // R9
  cause_capture_chk: assert property (@(posedge clk) disable iff (!por_n)
    (sys_rst && !in_rst_q) |=> (cause_q == $past(rst_req)));
endmodule

// File: rtl/bod_xing.sv
module bod_xing (
  input  logic clk,
  input  logic por_n,
  input  logic level,
  input  logic reload,
  input  logic reload_level,
  input  logic irq_en,
  output logic irq
);
  logic prev_q;
  logic irq_q;
  logic crossed;

  assign crossed = level ^ prev_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      prev_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= reload ? reload_level : level;
      irq_q  <= irq_en && crossed;
    end
  end

  assign irq = irq_q;

  // R4
  irq_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
    irq_q |-> $past(irq_en));
endmodule

// File: rtl/bod_ctrl.sv
module bod_ctrl
  import bod_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             sys_rst,
  input  logic             opt_off,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             cmp_supply_low,
  input  logic             cmp_ext_low,
  output logic             irq_pulse,
  output logic             rst_req,
  output logic             last_rst_self
);
  localparam int NSRC = 2;

  logic [NSRC-1:0] lv_sync;
  bod_cfg_t        cfg;
  logic            level_sel;
  logic            bus_write;
  logic            irq_en;
  logic            reload_level;

  bod_sync #(.STAGES(SYNC_STAGES), .WIDTH(NSRC)) u_sync (
    .clk   (clk),
    .por_n (por_n),
    .d     ({cmp_ext_low, cmp_supply_low}),
    .q     (lv_sync)
  );

  assign level_sel    = pick_level(cfg.src, lv_sync);
  assign rst_req      = cfg.arm && cfg.mode && level_sel;
  assign bus_write    = reg_we && !sys_rst;
  assign irq_en       = cfg.arm && !cfg.mode && !sys_rst;
  assign reload_level = pick_level(reg_wdata[SRC_BIT], lv_sync);

  bod_cfg_reg u_cfg (
    .clk     (clk),
    .por_n   (por_n),
    .opt_off (opt_off),
    .sys_rst (sys_rst),
    .wr_en   (reg_we),
    .wr_data (reg_wdata),
    .rst_req (rst_req),
    .cfg     (cfg),
    .cause   (last_rst_self)
  );

  bod_xing u_xing (
    .clk          (clk),
    .por_n        (por_n),
    .level        (level_sel),
    .reload       (bus_write),
    .reload_level (reload_level),
    .irq_en       (irq_en),
    .irq          (irq_pulse)
  );

  assign reg_rdata = pack_status(cfg, cfg.arm && level_sel);

  // R6
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
    $past(!cfg.arm) |-> !irq_pulse);
  // R5
  rst_mode_no_irq_chk: assert property (@(posedge clk) disable iff (!por_n)
    $past(cfg.mode) |-> !irq_pulse);
endmodule

// File: tb/tb_bod_ctrl.sv
`timescale 1ns/1ps
module tb_bod_ctrl;
  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       sys_rst = 1'b0;
  logic       opt_off = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       cmp_supply_low = 1'b0;
  logic       cmp_ext_low = 1'b0;
  logic       irq_pulse;
  logic       rst_req;
  logic       last_rst_self;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bod_ctrl dut (
    .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .opt_off(opt_off),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cmp_supply_low(cmp_supply_low), .cmp_ext_low(cmp_ext_low),
    .irq_pulse(irq_pulse), .rst_req(rst_req), .last_rst_self(last_rst_self)
  );

  // reference state (value after the most recent edge)
  logic [1:0] m_s1, m_s2;
  logic m_arm, m_src, m_mode, m_prev, m_irq, m_cause, m_inrst;
  logic cur_sup = 1'b0, cur_ext = 1'b0;
  int   irq_seen;

  function automatic logic sel(input logic s, input logic [1:0] v);
    if (s) return v[1];
    return v[0];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic lvl;
    logic [7:0] er;
    lvl = sel(m_src, m_s2);
    er  = {m_arm, 4'b0000, m_src, m_mode, m_arm & lvl};
    chk(reg_rdata[7:1] == er[7:1], "R1 register fields", reg_rdata, er);
    chk(reg_rdata[0] == er[0], "R2 flag", {7'd0, reg_rdata[0]}, {7'd0, er[0]});
    chk(irq_pulse == m_irq, "R4 irq", {7'd0, irq_pulse}, {7'd0, m_irq});
    chk(rst_req == (m_arm & m_mode & lvl), "R5 rst_req", {7'd0, rst_req}, {7'd0, m_arm & m_mode & lvl});
    chk(last_rst_self == m_cause, "R9 cause", {7'd0, last_rst_self}, {7'd0, m_cause});
  endtask

  task automatic step(input logic sup, input logic ext, input logic we,
                      input logic [7:0] wd, input logic srst);
    logic lvl, rq, n_irq, n_prev, entry, self_r, n_cause;
    logic n_arm, n_src, n_mode;
    cmp_supply_low = sup; cmp_ext_low = ext; cur_sup = sup; cur_ext = ext;
    reg_we = we; reg_wdata = wd; sys_rst = srst;
    lvl    = sel(m_src, m_s2);
    rq     = m_arm & m_mode & lvl;
    n_irq  = m_arm & ~m_mode & ~srst & (lvl ^ m_prev);
    n_prev = (we & ~srst) ? sel(wd[2], m_s2) : lvl;
    n_arm = m_arm; n_src = m_src; n_mode = m_mode; n_cause = m_cause;
    if (srst) begin
      entry  = ~m_inrst;
      self_r = entry ? rq : m_cause;
      if (entry) n_cause = rq;
      if (!self_r) begin n_arm = ~opt_off; n_src = 1'b0; n_mode = ~opt_off; end
    end else if (we) begin
      n_arm = wd[7]; n_src = wd[2]; n_mode = wd[1];
    end
    @(posedge clk);
    m_s2 = m_s1; m_s1 = {ext, sup};
    m_irq = n_irq; m_prev = n_prev; m_cause = n_cause; m_inrst = srst;
    m_arm = n_arm; m_src = n_src; m_mode = n_mode;
    @(negedge clk);
    reg_we = 1'b0;
    compare_all();
    if (irq_pulse) irq_seen++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(cur_sup, cur_ext, 1'b0, 8'h00, 1'b0);
  endtask

  task automatic wr(input logic [7:0] d);
    step(cur_sup, cur_ext, 1'b1, d, 1'b0);
  endtask

  task automatic power_on(input logic off);
    por_n = 1'b0; opt_off = off; sys_rst = 1'b0; reg_we = 1'b0;
    cmp_supply_low = 1'b0; cmp_ext_low = 1'b0; cur_sup = 1'b0; cur_ext = 1'b0;
    repeat (2) @(negedge clk);
    m_s1 = '0; m_s2 = '0; m_prev = 1'b0; m_irq = 1'b0; m_cause = 1'b0; m_inrst = 1'b0;
    m_arm = ~off; m_src = 1'b0; m_mode = ~off;
    por_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin : watchdog
    #500000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd4242));

    // R8 power-on defaults for both option values
    power_on(1'b1);
    chk(reg_rdata == 8'h00, "R8 por opt_off=1", reg_rdata, 8'h00);
    power_on(1'b0);
    chk(reg_rdata == 8'h82, "R8 por opt_off=0", reg_rdata, 8'h82);
    chk(irq_pulse == 1'b0 && rst_req == 1'b0 && last_rst_self == 1'b0, "R8 outputs idle",
        {5'd0, irq_pulse, rst_req, last_rst_self}, 8'h00);
    idle(3);

    // R1 / R3: write all ones, bit 0 must follow the comparator (low here)
    wr(8'hFF);
    chk(reg_rdata == 8'h86, "R3 flag not writable", reg_rdata, 8'h86);
    step(1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
    idle(2);
    chk(reg_rdata == 8'h87 && rst_req, "R5 ext low asserts request", reg_rdata, 8'h87);
    step(1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    idle(2);
    chk(rst_req == 1'b0, "R5 request released", {7'd0, rst_req}, 8'h00);

    // R6: disabled, toggle supply
    wr(8'h00);
    irq_seen = 0;
    for (int i = 0; i < 6; i++) begin
      step(~cur_sup, cur_ext, 1'b0, 8'h00, 1'b0);
      chk(reg_rdata[0] == 1'b0 && rst_req == 1'b0, "R6 quiet while off", reg_rdata, 8'h00);
    end
    idle(3);
    chk(irq_seen == 0, "R6 no irq while off", irq_seen[7:0], 8'h00);

    // R7: enable with level already low, then switch source across a difference
    step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
    idle(3);
    irq_seen = 0;
    wr(8'h80);
    idle(3);
    chk(irq_seen == 0, "R7 no irq on enable", irq_seen[7:0], 8'h00);
    wr(8'h84);
    idle(4);
    chk(irq_seen == 0, "R7 no irq on source switch", irq_seen[7:0], 8'h00);
    wr(8'h80);
    idle(4);
    chk(irq_seen == 0, "R7 no irq on switch back", irq_seen[7:0], 8'h00);

    // R4: fall then rise on supply, irq after third edge, one cycle each
    step(1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    step(1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    chk(irq_pulse == 1'b0, "R4 no irq before third edge", {7'd0, irq_pulse}, 8'h00);
    step(1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    chk(irq_pulse == 1'b1, "R4 irq on return", {7'd0, irq_pulse}, 8'h01);
    step(1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    chk(irq_pulse == 1'b0, "R4 single cycle", {7'd0, irq_pulse}, 8'h00);
    irq_seen = 0;
    step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
    idle(5);
    chk(irq_seen == 1, "R4 one irq on fall", irq_seen[7:0], 8'h01);

    // R9 / R10: self reset keeps config, write during it ignored
    step(1'b0, 1'b0, 1'b1, 8'h86, 1'b0);
    step(1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
    idle(2);
    chk(rst_req == 1'b1, "R9 request before reset", {7'd0, rst_req}, 8'h01);
    step(1'b0, 1'b1, 1'b0, 8'h00, 1'b1);
    step(1'b0, 1'b1, 1'b1, 8'h00, 1'b1);
    chk(reg_rdata[7:1] == 7'h43, "R10 write ignored in reset", reg_rdata, 8'h86);
    step(1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
    step(1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
    step(1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
    chk(rst_req == 1'b0 && reg_rdata == 8'h86, "R9 config kept", reg_rdata, 8'h86);
    step(1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    chk(last_rst_self == 1'b1, "R9 cause reported", {7'd0, last_rst_self}, 8'h01);
    // plain reset now: full reload
    step(1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
    step(1'b0, 1'b0, 1'b1, 8'h86, 1'b1);
    step(1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    chk(reg_rdata == 8'h82 && last_rst_self == 1'b0, "R8 plain reset reloads", reg_rdata, 8'h82);

    // constrained random against the model
    for (int i = 0; i < 4000; i++) begin
      logic s, e, w, r;
      logic [7:0] d;
      s = ($urandom_range(0, 7) == 0) ? ~cur_sup : cur_sup;
      e = ($urandom_range(0, 7) == 0) ? ~cur_ext : cur_ext;
      w = ($urandom_range(0, 15) == 0);
      d = 8'($urandom) & 8'h87;
      if ($urandom_range(0, 1) == 1) d[1] = 1'b0;
      r = (rst_req && $urandom_range(0, 3) == 0) || ($urandom_range(0, 199) == 0);
      step(s, e, w, d, r);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule